// File: doc/BRIEF.md
# Paged LED Matrix Register Target on I2C

This block is the host-facing register front end of a matrix LED controller. It listens on an I2C bus that is oversampled by the system clock, answers to one 7-bit target address whose two low bits come from a board strap, and gives the host byte access to a paged register space. A write transaction carries a register pointer followed by any number of data bytes, and the pointer steps by one per byte. A read is done by writing the pointer, issuing a repeated START and then clocking bytes out, again with the pointer stepping per byte.

Four data pages hold per-dot bytes: two pages of PWM duty values and two pages of scaling values, each pair split into a longer and a shorter page. A fifth page holds a few function registers. Three global registers sit above the pages: a page selector, a lock that must be opened with a key byte before every page change, and an identity register that echoes the target's own write address. A key byte written to the reset register of the function page returns everything to its power-on state; the page memory is cleared by a sweep so that it can live in block RAM.

Top module: `ledpg_i2c_regs`

## Requirements
- R1: The target acknowledges only the address byte whose upper seven bits equal binary 01100 followed by the strap value (strap 2'b10 gives write byte 0x64). Any other address gets no acknowledge, and no byte after it is acknowledged or stored until the next START.
- R2: In a write, the first byte after the address is the register pointer; each later byte is stored at the pointer, and the pointer then advances by one, so a burst fills consecutive offsets.
- R3: Register 0xFD holds the page, read back as its value. Pages 0 and 1 are PWM pages with last offsets 0xB3 and 0xAA, pages 2 and 3 are scaling pages with the same limits, and page 4 is the function page (0x00 configuration, 0x01 global current, 0x02 pull-resistor select). A page value of 5 or more is discarded and the page is unchanged.
- R4: A write to 0xFD changes the page only while lock register 0xFE holds 0xC5. Every write to 0xFD, taken or not, clears 0xFE to 0x00. 0xFE reads back its value.
- R5: Register 0xFC is read-only and reads as the target's write address byte {01100, strap, 0}.
- R6: A read (pointer write, repeated START, address with R/W = 1) returns the addressed byte MSB first; after each byte the host acknowledges, the pointer advances and the next byte follows; after a NACK the target leaves SDA released.
- R7: Writing 0xAE to page 4 offset 0x3F restores every register to its default: page 0, lock 0x00, configuration 0x00, global current 0x00, pull select 0x55, all page bytes 0x00. The same state follows the reset input. The restore takes at most 1100 clock cycles, during which writes are discarded.
- R8: Writes to read-only or undefined locations (page 4 offsets other than 0x00 to 0x02 and the reset key, data-page offsets past the page's last offset, global offsets other than 0xFD and 0xFE) change nothing, and reads from undefined locations return 0x00.
- R9: The target pulls SDA low through the ninth SCL pulse after a matching address, the pointer byte and every written byte, and changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| strap_i | input | 2 | Strap value forming the low two address bits |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |

## Verification
A wrong pointer or page shows at the ports on the next read burst: the scoreboard pairs every byte clocked out with the value the requirements predict, so a misplaced write or a skipped increment appears within one transaction as a wrong byte. A lock that fails to re-arm or a page that accepts an illegal value becomes visible as soon as 0xFD and 0xFE are read back, which the bench does right after every page attempt. A misdecoded address or a missed acknowledge shows in the very ACK bit of the byte concerned, and an unfinished clear sweep shows as a non-zero page byte read after a soft reset.

// File: rtl/ledpg_pkg.sv
package ledpg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_t;

  localparam logic [4:0] ADDR_PREFIX  = 5'b01100;
  localparam logic [3:0] GLOBAL_NIB   = 4'hF;
  localparam logic [7:0] REG_ID       = 8'hFC;
  localparam logic [7:0] REG_PAGE     = 8'hFD;
  localparam logic [7:0] REG_LOCK     = 8'hFE;
  localparam logic [7:0] UNLOCK_KEY   = 8'hC5;
  localparam logic [7:0] RESET_KEY    = 8'hAE;
  localparam logic [7:0] OFS_CFG      = 8'h00;
  localparam logic [7:0] OFS_GCUR     = 8'h01;
  localparam logic [7:0] OFS_PULL     = 8'h02;
  localparam logic [7:0] OFS_RESET    = 8'h3F;
  localparam logic [7:0] PULL_DEFAULT = 8'h55;

endpackage

// File: rtl/ledpg_bus_sync.sv
module ledpg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ledpg_target_fsm.sv
module ledpg_target_fsm
  import ledpg_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [1:0]    strap_i,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);

  localparam logic [3:0] LAST_BIT = 4'd8;

  tgt_state_t state;
  byte_kind_t kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       rnw;
  logic       ack_ok;
  logic       addr_hit;

  assign addr_hit = (shreg[7:1] == {ADDR_PREFIX, strap_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind    <= BK_ADDR;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      rnw     <= 1'b0;
      ack_ok  <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        kind   <= BK_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != LAST_BIT) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (kind == BK_ADDR) begin
                if (addr_hit) begin
                  rnw    <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_RX_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
                if (kind == BK_PTR) begin
                  ptr <= AW'(shreg);
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr + AW'(1);
                end
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (kind == BK_ADDR && rnw) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
                kind   <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ack_ok <= ~sda_s;
              if (!sda_s) ptr <= ptr + AW'(1);
            end else if (scl_fall) begin
              if (ack_ok) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                bitcnt <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: an unselected or finished target never drives the bus
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R9: the drive is asserted only while SCL is low
  assert_ack_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R2: each stored byte leaves the pointer one past its address
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (ptr == wr_addr + AW'(1)));

endmodule

// File: rtl/ledpg_regfile.sv
module ledpg_regfile
  import ledpg_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          DATA_PAGES = 4,
  parameter logic [7:0]  LAST_EVEN  = 8'hB3,
  parameter logic [7:0]  LAST_ODD   = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    strap_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  localparam int PAGE_BITS = $clog2(DATA_PAGES);
  localparam int PAGE_W    = $clog2(DATA_PAGES + 1);
  localparam int RAM_AW    = PAGE_BITS + AW;
  localparam int RAM_DEPTH = DATA_PAGES << AW;
  localparam logic [PAGE_W-1:0] FUNC_PAGE = PAGE_W'(DATA_PAGES);

  logic [PAGE_W-1:0] page;
  logic [7:0] lock, cfg, gcur, pull;
  logic       busy;
  logic [RAM_AW-1:0] sweep_cnt;

  logic [7:0] mem [RAM_DEPTH];
  logic [7:0] ram_q;
  logic       ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [7:0] ram_wdata;

  logic wr_ok, wr_global, rd_global, soft_hit;
  logic [7:0] wr_last, rd_last, rd_other_d, rd_other;
  logic       rd_from_ram;

  assign wr_ok     = wr_en && !busy;
  assign wr_global = (wr_addr[AW-1:AW-4] == GLOBAL_NIB);
  assign rd_global = (rd_addr[AW-1:AW-4] == GLOBAL_NIB);
  assign wr_last   = page[0] ? LAST_ODD : LAST_EVEN;
  assign rd_last   = wr_last;
  assign soft_hit  = wr_ok && !wr_global && page == FUNC_PAGE &&
                     wr_addr == AW'(OFS_RESET) && wr_data == RESET_KEY;

  // page memory: one write port shared with the clear sweep, one read port
  assign ram_we    = busy || (wr_ok && !wr_global && page < FUNC_PAGE &&
                              8'(wr_addr) <= wr_last);
  assign ram_waddr = busy ? sweep_cnt : {page[PAGE_BITS-1:0], wr_addr};
  assign ram_wdata = busy ? 8'h00 : wr_data;
  assign ram_raddr = {page[PAGE_BITS-1:0], rd_addr};

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_waddr] <= ram_wdata;
    ram_q <= mem[ram_raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page      <= '0;
      lock      <= 8'h00;
      cfg       <= 8'h00;
      gcur      <= 8'h00;
      pull      <= PULL_DEFAULT;
      busy      <= 1'b1;
      sweep_cnt <= '0;
    end else if (soft_hit) begin
      page      <= '0;
      lock      <= 8'h00;
      cfg       <= 8'h00;
      gcur      <= 8'h00;
      pull      <= PULL_DEFAULT;
      busy      <= 1'b1;
      sweep_cnt <= '0;
    end else begin
      if (busy) begin
        sweep_cnt <= sweep_cnt + RAM_AW'(1);
        if (sweep_cnt == RAM_AW'(RAM_DEPTH - 1)) busy <= 1'b0;
      end
      if (wr_ok) begin
        if (wr_addr == AW'(REG_LOCK)) begin
          lock <= wr_data;
        end else if (wr_addr == AW'(REG_PAGE)) begin
          lock <= 8'h00;
          if (lock == UNLOCK_KEY && wr_data <= 8'(FUNC_PAGE))
            page <= PAGE_W'(wr_data);
        end else if (!wr_global && page == FUNC_PAGE) begin
          case (8'(wr_addr))
            OFS_CFG:  cfg  <= wr_data;
            OFS_GCUR: gcur <= wr_data;
            OFS_PULL: pull <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_other_d = 8'h00;
    if (rd_global) begin
      case (8'(rd_addr))
        REG_ID:   rd_other_d = {ADDR_PREFIX, strap_i, 1'b0};
        REG_PAGE: rd_other_d = 8'(page);
        REG_LOCK: rd_other_d = lock;
        default:  rd_other_d = 8'h00;
      endcase
    end else if (page == FUNC_PAGE) begin
      case (8'(rd_addr))
        OFS_CFG:  rd_other_d = cfg;
        OFS_GCUR: rd_other_d = gcur;
        OFS_PULL: rd_other_d = pull;
        default:  rd_other_d = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_from_ram <= 1'b0;
      rd_other    <= 8'h00;
    end else begin
      rd_from_ram <= !rd_global && page < FUNC_PAGE && 8'(rd_addr) <= rd_last;
      rd_other    <= rd_other_d;
    end
  end

  assign rd_data = rd_from_ram ? ram_q : rd_other;

  // R3: the page never holds an illegal value
  always_ff @(posedge clk) begin
    if (!rst) assert_page_legal_R3: assert (page <= FUNC_PAGE);
  end

  // R4: any page-select write re-arms the lock
  assert_lock_rearm_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && wr_addr == AW'(REG_PAGE)) |=> (lock == 8'h00));

  // R4: without the key the page does not move
  assert_locked_page_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && wr_addr == AW'(REG_PAGE) && lock != UNLOCK_KEY) |=> $stable(page));

  // R7: the reset key restores the pull default and starts the clear sweep
  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (rst)
    soft_hit |=> (pull == PULL_DEFAULT && busy && page == '0));

endmodule

// File: rtl/ledpg_i2c_regs.sv
module ledpg_i2c_regs
  import ledpg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         AW          = 8,
  parameter int         DATA_PAGES  = 4,
  parameter logic [7:0] LAST_EVEN   = 8'hB3,
  parameter logic [7:0] LAST_ODD    = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe_o
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] ptr, wr_addr;
  logic [7:0] wr_data, rd_data;
  logic wr_en;

  ledpg_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ledpg_target_fsm #(.AW(AW)) i_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .strap_i(strap_i),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  ledpg_regfile #(
    .AW(AW), .DATA_PAGES(DATA_PAGES), .LAST_EVEN(LAST_EVEN), .LAST_ODD(LAST_ODD)
  ) i_regs (
    .clk(clk), .rst(rst), .strap_i(strap_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
  );

endmodule

// File: tb/test_ledpg_i2c_regs.sv
module test_ledpg_i2c_regs;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 5;
  localparam int WATCHDOG   = 150000;
  localparam int SWEEP_WAIT = 1100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ledpg_i2c_regs i_ledpg_i2c_regs (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every byte read from the bus with its prediction
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        t = (tag_q.size() > 0) ? tag_q.pop_front() : "unexpected byte";
        chk(g === e, t, g, e);
      end
    end
  end

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic r);
    qwait(); sda_m = b; qwait(); scl_m = 1'b1; qwait();
    r = sda_line; qwait(); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait();
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic byte_out(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], r);
    xfer_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic byte_in(input bit send_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(1'b1, r);
      v[i] = r;
    end
    xfer_bit(~send_ack, r);
  endtask

  task automatic wr_burst(input logic [6:0] dev, input logic [7:0] ptr,
                          input logic [7:0] d [4], input int n,
                          input bit exp_ack, input string tag);
    bit a;
    bus_start();
    byte_out({dev, 1'b0}, a);
    chk(a == exp_ack, {tag, " address ack"}, 8'(a), 8'(exp_ack));
    byte_out(ptr, a);
    chk(a == exp_ack, {tag, " pointer ack"}, 8'(a), 8'(exp_ack));
    for (int i = 0; i < n; i++) begin
      byte_out(d[i], a);
      chk(a == exp_ack, {tag, " data ack"}, 8'(a), 8'(exp_ack));
    end
    bus_stop();
  endtask

  task automatic wr1(input logic [6:0] dev, input logic [7:0] ptr,
                     input logic [7:0] d, input string tag);
    wr_burst(dev, ptr, '{d, 8'h00, 8'h00, 8'h00}, 1, 1'b1, tag);
  endtask

  task automatic rd_burst(input logic [6:0] dev, input logic [7:0] ptr,
                          input int n, input logic [7:0] e [4], input string tag);
    bit a;
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e[i]);
      tag_q.push_back(tag);
    end
    bus_start();
    byte_out({dev, 1'b0}, a);
    chk(a, {tag, " read setup ack"}, 8'(a), 8'h01);
    byte_out(ptr, a);
    chk(a, {tag, " read pointer ack"}, 8'(a), 8'h01);
    bus_start();
    byte_out({dev, 1'b1}, a);
    chk(a, {tag, " read address ack"}, 8'(a), 8'h01);
    for (int i = 0; i < n; i++) begin
      byte_in(i != n - 1, v);
      got_q.push_back(v);
    end
    qwait();
    chk(sda_oe == 1'b0, "R6 SDA released after NACK", 8'(sda_oe), 8'h00);
    bus_stop();
  endtask

  task automatic set_page(input logic [6:0] dev, input logic [7:0] p, input string tag);
    wr1(dev, 8'hFE, 8'hC5, tag);
    wr1(dev, 8'hFD, p, tag);
  endtask

  localparam logic [6:0] DEV   = 7'h32;
  localparam logic [6:0] BAD   = 7'h38;
  localparam logic [6:0] DEV01 = 7'h31;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sda_oe == 1'b0, "R9 reset: SDA not driven", 8'(sda_oe), 8'h00);
    repeat (SWEEP_WAIT) @(negedge clk);

    // R1: foreign address is ignored entirely
    wr_burst(BAD, 8'hFE, '{8'hC5, 8'h5A, 8'h00, 8'h00}, 2, 1'b0, "R1 foreign address");
    rd_burst(DEV, 8'hFE, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R1 foreign write not stored");

    // R5: identity, R3 default page
    rd_burst(DEV, 8'hFC, 2, '{8'h64, 8'h00, 8'h00, 8'h00}, "R5 identity and R3 default page");

    // R4: page change without key is refused
    wr1(DEV, 8'hFD, 8'h04, "R4 locked write");
    rd_burst(DEV, 8'hFD, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R4 page unchanged while locked");

    // R4: key then page write; lock re-arms; R6 sequential read
    wr1(DEV, 8'hFE, 8'hC5, "R4 key");
    rd_burst(DEV, 8'hFE, 1, '{8'hC5, 8'h00, 8'h00, 8'h00}, "R4 lock readback");
    wr1(DEV, 8'hFD, 8'h04, "R4 unlocked write");
    rd_burst(DEV, 8'hFC, 3, '{8'h64, 8'h04, 8'h00, 8'h00}, "R6 burst read id/page/lock R4");

    // R7 defaults on the function page, R2 burst write
    rd_burst(DEV, 8'h00, 3, '{8'h00, 8'h00, 8'h55, 8'h00}, "R7 function defaults");
    wr_burst(DEV, 8'h00, '{8'h11, 8'h22, 8'h00, 8'h00}, 2, 1'b1, "R2 burst write");
    rd_burst(DEV, 8'h00, 2, '{8'h11, 8'h22, 8'h00, 8'h00}, "R2 burst readback");

    // R8: read-only and undefined locations
    wr1(DEV, 8'h05, 8'h99, "R8 read-only write");
    wr1(DEV, 8'hF0, 8'h12, "R8 undefined global write");
    rd_burst(DEV, 8'h04, 2, '{8'h00, 8'h00, 8'h00, 8'h00}, "R8 read-only stays zero");
    rd_burst(DEV, 8'hF0, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R8 undefined global reads zero");

    // R3: illegal page value refused, lock still consumed (R4)
    set_page(DEV, 8'h07, "R3 illegal page");
    rd_burst(DEV, 8'hFD, 2, '{8'h04, 8'h00, 8'h00, 8'h00}, "R3 page kept, R4 lock cleared");

    // R2/R8: burst across the end of the short PWM page
    set_page(DEV, 8'h01, "R3 select page 1");
    wr_burst(DEV, 8'hA9, '{8'h31, 8'h32, 8'h33, 8'h00}, 3, 1'b1, "R2 burst to page end");
    rd_burst(DEV, 8'hA9, 3, '{8'h31, 8'h32, 8'h00, 8'h00}, "R8 past page end discarded");

    // R3: pages are separate storage
    set_page(DEV, 8'h00, "R3 select page 0");
    wr1(DEV, 8'hB3, 8'h44, "R3 last offset of long page");
    rd_burst(DEV, 8'hB2, 2, '{8'h00, 8'h44, 8'h00, 8'h00}, "R3 long page last offset");
    rd_burst(DEV, 8'hA9, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R3 page 0 separate from page 1");

    // R7: soft reset restores everything
    set_page(DEV, 8'h04, "R7 select function page");
    wr1(DEV, 8'h01, 8'h77, "R7 set global current");
    wr1(DEV, 8'h3F, 8'hAE, "R7 reset key");
    repeat (SWEEP_WAIT) @(negedge clk);
    rd_burst(DEV, 8'hFC, 3, '{8'h64, 8'h00, 8'h00, 8'h00}, "R7 page and lock default");
    rd_burst(DEV, 8'hB3, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R7 page byte cleared");
    set_page(DEV, 8'h01, "R7 back to page 1");
    rd_burst(DEV, 8'hA9, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R7 page 1 cleared");
    set_page(DEV, 8'h04, "R7 back to function page");
    rd_burst(DEV, 8'h00, 3, '{8'h00, 8'h00, 8'h55, 8'h00}, "R7 function registers default");

    // R1/R5: strap change moves the address
    strap = 2'b01;
    repeat (10) @(negedge clk);
    wr_burst(DEV, 8'hFE, '{8'hC5, 8'h00, 8'h00, 8'h00}, 1, 1'b0, "R1 old address after strap change");
    rd_burst(DEV01, 8'hFE, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R1 ignored write left lock");
    rd_burst(DEV01, 8'hFC, 1, '{8'h62, 8'h00, 8'h00, 8'h00}, "R5 identity follows strap");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all predicted bytes read", 8'(exp_q.size()), 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule